// File: doc/BRIEF.md
# Write-Response Token Checker

After a block has been written to a card, the card reports on its data line whether it received the block correctly. This block watches that line, one sample per strobe, and sorts the outcome into one of four results. The block was accepted and the card has released its busy hold. The card rejected the block. The token frame was malformed. No token arrived in time.

The host issues a one-cycle start pulse after the last bit of a written block has gone out. From then on the block acts only on samples that carry a strobe. It first looks for a low start bit within a fixed window. It then collects three status bits and an end bit. If the token is good, it waits for the line to go high again before it reports completion. A missing token is reported as a hard error, so the block never waits for ever on a silent card. Every result, once reported, holds until the next start pulse or reset.

Top module: `wr_token_chk`

## Requirements
- R1: While reset is asserted and after it is released, `done_o`, `ok_o`, `crc_err_o`, `tmo_err_o` and `frm_err_o` are all 0.
- R2: A start pulse clears all outputs to 0 and begins the search for a start bit. A strobe in the same cycle as the start pulse is not sampled.
- R3: A change of `dat_i` without `dat_stb_i` has no effect on any output or on the token being collected.
- R4: The token begins at the first strobed 0 among the first 16 strobes after start. If all of the first 16 strobes sample 1, `tmo_err_o` and `done_o` are set on the 16th.
- R5: The token is a start bit 0, then three status bits with the first-sampled bit as MSB, then an end bit 1. Status 3'b010 with end bit 1 means accepted.
- R6: After an accepted token, `done_o` and `ok_o` are set on the first later strobe that samples 1. Strobes that sample 0 (card busy) keep `done_o` at 0.
- R7: With end bit 1 and any status other than 3'b010, `crc_err_o` and `done_o` are set on the end-bit strobe.
- R8: With end bit 0, `frm_err_o` and `done_o` are set on the end-bit strobe, whatever the status.
- R9: Each result appears in the clock cycle after the edge that samples its deciding strobe. Once `done_o` is set, all outputs hold until the next start pulse or reset, whatever the line or strobe does. At most one of the four result flags is ever set, and a set flag always comes with `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse after the last bit of a written block |
| dat_i | input | 1 | Sampled data line 0 |
| dat_stb_i | input | 1 | Marks the cycles in which `dat_i` is a valid sample |
| done_o | output | 1 | Checking has finished; a result flag is valid |
| ok_o | output | 1 | Token accepted and busy released |
| crc_err_o | output | 1 | Token reports that the card rejected the block |
| tmo_err_o | output | 1 | No start bit within the window |
| frm_err_o | output | 1 | End bit of the token was 0 |

## Verification
All results are registered. A result is due one clock edge after the strobe that decides it. The bench drives on the falling edge and samples on the next falling edge, so the first look after the deciding strobe already sees the result. Before each deciding strobe the bench checks that `done_o` is still 0; this pins the result to the exact strobe (16th window strobe, end bit, first released-busy sample). The scoreboard queue then matches the flags against the expected outcome once `done_o` rises.

// File: rtl/wr_token_pkg.sv
package wr_token_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HUNT,
    ST_RECV,
    ST_BUSY,
    ST_DONE
  } tok_state_e;

  typedef struct packed {
    logic ok;
    logic crc;
    logic tmo;
    logic frm;
  } tok_res_t;
endpackage

// File: rtl/wr_token_win.sv
// Counts strobed idle samples while hunting for the start bit.
module wr_token_win #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic expire_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i && cnt_q != CW'(LIMIT - 1)) cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = inc_i && (cnt_q == CW'(LIMIT - 1));

  // R4
  win_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(LIMIT - 1));
endmodule

// File: rtl/wr_token_sr.sv
// Collects the bits that follow the start bit; last_o flags the final one.
module wr_token_sr #(
  parameter int unsigned LEN = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            shift_i,
  input  logic            bit_i,
  output logic [LEN-2:0]  data_o,
  output logic            last_o
);
  localparam int unsigned DW = LEN - 1;
  localparam int unsigned CW = $clog2(LEN + 1);

  logic [DW-1:0] data_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      cnt_q  <= '0;
    end else if (clr_i) begin
      data_q <= '0;
      cnt_q  <= '0;
    end else if (shift_i) begin
      data_q <= (data_q << 1) | DW'(bit_i);
      cnt_q  <= last_o ? '0 : cnt_q + 1'b1;
    end
  end

  assign last_o = shift_i && (cnt_q == CW'(LEN - 1));
  assign data_o = data_q;

  // R5
  sr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(LEN - 1));
endmodule

// File: rtl/wr_token_chk.sv
module wr_token_chk
  import wr_token_pkg::*;
#(
  parameter int unsigned START_WIN   = 16,
  parameter int unsigned STAT_W      = 3,
  parameter logic [STAT_W-1:0] ACCEPT_CODE = 3'b010
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic dat_i,
  input  logic dat_stb_i,
  output logic done_o,
  output logic ok_o,
  output logic crc_err_o,
  output logic tmo_err_o,
  output logic frm_err_o
);
  localparam int unsigned TOK_LEN = STAT_W + 1; // status + end bit

  tok_state_e st_q;
  tok_res_t   res_q;
  logic       done_q;

  logic              stb;
  logic              expire;
  logic              last;
  logic [STAT_W-1:0] stat;

  assign stb = dat_stb_i && !start_i;

  wr_token_win #(.LIMIT(START_WIN)) u_win (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (start_i),
    .inc_i    (stb && st_q == ST_HUNT && dat_i),
    .expire_o (expire)
  );

  wr_token_sr #(.LEN(TOK_LEN)) u_sr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (start_i),
    .shift_i (stb && st_q == ST_RECV),
    .bit_i   (dat_i),
    .data_o  (stat),
    .last_o  (last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      res_q  <= '0;
      done_q <= 1'b0;
    end else if (start_i) begin
      st_q   <= ST_HUNT;
      res_q  <= '0;
      done_q <= 1'b0;
    end else if (stb) begin
      unique case (st_q)
        ST_HUNT: begin
          if (!dat_i) begin
            st_q <= ST_RECV;
          end else if (expire) begin
            res_q.tmo <= 1'b1;
            done_q    <= 1'b1;
            st_q      <= ST_DONE;
          end
        end
        ST_RECV: begin
          if (last) begin
            if (!dat_i) begin
              res_q.frm <= 1'b1;
              done_q    <= 1'b1;
              st_q      <= ST_DONE;
            end else if (stat == ACCEPT_CODE) begin
              st_q <= ST_BUSY;
            end else begin
              res_q.crc <= 1'b1;
              done_q    <= 1'b1;
              st_q      <= ST_DONE;
            end
          end
        end
        ST_BUSY: begin
          if (dat_i) begin
            res_q.ok <= 1'b1;
            done_q   <= 1'b1;
            st_q     <= ST_DONE;
          end
        end
        default: ;
      endcase
    end
  end

  assign done_o    = done_q;
  assign ok_o      = res_q.ok;
  assign crc_err_o = res_q.crc;
  assign tmo_err_o = res_q.tmo;
  assign frm_err_o = res_q.frm;

  // R9
  one_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ok_o, crc_err_o, tmo_err_o, frm_err_o}));

  // R9
  flag_has_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ok_o || crc_err_o || tmo_err_o || frm_err_o) |-> done_o);

  // R2
  start_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !(done_o || ok_o || crc_err_o || tmo_err_o || frm_err_o));

  // R9
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=>
      $stable({done_o, ok_o, crc_err_o, tmo_err_o, frm_err_o}));

  // R3
  no_strobe_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dat_stb_i && !start_i) |=>
      $stable({done_o, ok_o, crc_err_o, tmo_err_o, frm_err_o}));

  // R6
  ok_needs_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ok_o) |-> $past(dat_i && dat_stb_i));
endmodule

// File: tb/wr_token_chk_tb_top.sv
module wr_token_chk_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic dat = 1'b1;
  logic stb = 1'b0;
  logic done, ok, crc, tmo, frm;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic [3:0] flags; // {ok, crc, tmo, frm}
    string      tag;
  } exp_t;
  exp_t exp_q[$];

  always #2 clk = ~clk;

  wr_token_chk dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .start_i   (start),
    .dat_i     (dat),
    .dat_stb_i (stb),
    .done_o    (done),
    .ok_o      (ok),
    .crc_err_o (crc),
    .tmo_err_o (tmo),
    .frm_err_o (frm)
  );

  wire [4:0] obs = {done, ok, crc, tmo, frm};

  task automatic check(string tag, logic [4:0] act, logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%b exp=%b", tag, act, exp);
    end
  endtask

  task automatic pulse_start(logic with_stb = 1'b0, logic b = 1'b1);
    @(negedge clk);
    start = 1'b1; stb = with_stb; dat = b;
    @(negedge clk);
    start = 1'b0; stb = 1'b0;
  endtask

  task automatic send(logic b);
    @(negedge clk);
    dat = b; stb = 1'b1;
    @(negedge clk);
    stb = 1'b0;
  endtask

  task automatic token(logic [2:0] st, logic e);
    send(1'b0);
    send(st[2]); send(st[1]); send(st[0]);
    send(e);
  endtask

  // monitor: pops one expectation per rising done
  logic seen = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (done && !seen) begin
        seen <= 1'b1;
        checks++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R9 unexpected result act=%b exp=none", obs);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          if ({ok, crc, tmo, frm} !== e.flags) begin
            fails++;
            $display("FAIL %s act=%b exp=%b", e.tag, {ok, crc, tmo, frm}, e.flags);
          end
        end
      end else if (!done) begin
        seen <= 1'b0;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", obs, 5'b0);
    rst_n = 1'b1;
    // R3: strobes before any start have no effect
    send(1'b0); send(1'b1);
    check("R1 after reset", obs, 5'b0);

    // R5/R6: accepted, released at once
    pulse_start();
    send(1'b1); send(1'b1);
    token(3'b010, 1'b1);
    check("R6 waiting release", obs, 5'b0);
    exp_q.push_back('{4'b1000, "R5 accept"});
    send(1'b1);
    check("R9 ok visible next cycle", obs, 5'b11000);

    // R2: start clears
    pulse_start();
    check("R2 cleared", obs, 5'b0);

    // R6: busy held several strobes; R3: line toggles without strobe
    send(1'b0); send(1'b0); send(1'b1); send(1'b0); send(1'b1);
    for (int i = 0; i < 5; i++) send(1'b0);
    @(negedge clk); dat = 1'b1;
    @(negedge clk); dat = 1'b0;
    check("R6 busy keeps done low", obs, 5'b0);
    exp_q.push_back('{4'b1000, "R6 busy release"});
    send(1'b1);

    // R7: rejection codes
    pulse_start();
    send(1'b0); send(1'b1); send(1'b0);
    @(negedge clk); dat = 1'b0; // unstrobed, must not shift (R3)
    send(1'b1);
    check("R7 before end bit", obs, 5'b0);
    exp_q.push_back('{4'b0100, "R7 status 101"});
    send(1'b1);
    // R9: further strobes ignored
    send(1'b0); send(1'b1); send(1'b0);
    check("R9 hold after done", obs, 5'b10100);

    pulse_start();
    exp_q.push_back('{4'b0100, "R7 status 110"});
    token(3'b110, 1'b1);

    // R8: framing
    pulse_start();
    exp_q.push_back('{4'b0001, "R8 end bit 0"});
    token(3'b010, 1'b0);
    check("R8 frame flag", obs, 5'b10001);

    // R4: timeout on 16th idle strobe
    pulse_start();
    for (int i = 0; i < 15; i++) send(1'b1);
    check("R4 no timeout at 15", obs, 5'b0);
    exp_q.push_back('{4'b0010, "R4 timeout"});
    send(1'b1);
    check("R4 timeout flag", obs, 5'b10010);

    // R4: start bit on the 16th strobe is still in time
    pulse_start();
    for (int i = 0; i < 15; i++) send(1'b1);
    token(3'b010, 1'b1);
    exp_q.push_back('{4'b1000, "R4 late start bit"});
    send(1'b1);

    // R2: strobe with start is not sampled (a low there would frame a bad token)
    pulse_start(1'b1, 1'b0);
    send(1'b0); send(1'b1); send(1'b0); send(1'b1); // 0 start, 101 reject
    check("R2 same-cycle strobe ignored", obs, 5'b0);
    exp_q.push_back('{4'b0100, "R2 token after start strobe"});
    send(1'b1);

    repeat (3) @(negedge clk);
    check("R9 all results seen", 5'(exp_q.size()), 5'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule